// File: doc/BRIEF.md
# Multi-Mode Encoder Position Counter

This block counts the position of a shaft encoder from its two digital outputs, called A and B. Each input first passes through a two-flop synchroniser and then a glitch filter. The filter accepts a new level only after that level has been seen for a set number of consecutive samples. The block then decodes edges on the clean signals, and the resulting up or down steps drive a position register.

A field in the decoder control register selects one of four counting modes:

- **Quadrature.** Every edge of A and of B counts, which gives four counts per encoder cycle.
- **Pulse plus direction.** A is the step clock and B is the direction.
- **Up only.** Only A is used. It counts on rising edges, or on both edges if a separate bit asks for that.
- **Down only.** The same as up only, counting the other way.

A simple write/read register port gives software access to the position, a ceiling, a reload value, the decoder control word and a control word. The control word holds the enable bit. The position wraps between zero and the ceiling. Clearing the enable bit reloads the position from the reload value.

Top module: `enc_pos_counter`

## Requirements
- R1: After reset the position is 0, the reload value is 0, the ceiling is all ones, counting is disabled, and the mode field and the both-edges bit are 0.
- R2: The registers sit at these byte offsets:
  - 0x00: position.
  - 0x04: reload value.
  - 0x08: ceiling.
  - 0x28: decoder control. The mode is in bits 15:14 and the both-edges bit is bit 11; every other bit reads 0.
  - 0x2A: control. The enable is bit 3; every other bit reads 0.
  - Any other offset reads 0.
- R3: Mode 0 (quadrature) counts each single change of A or B. The state sequence {A,B} = 00, 10, 11, 01 counts up, and the reverse sequence counts down.
- R4: In mode 0, a step in which A and B change together produces no count.
- R5: Mode 1 (pulse plus direction) counts only rising edges of A. It counts up when B is 1 and down when B is 0. Falling edges of A and any edge of B do not count.
- R6: Mode 2 counts up and mode 3 counts down. In both modes B is ignored. A counts on rising edges when bit 11 is 0 and on both edges when bit 11 is 1.
- R7: While the enable bit is 0, steps do not change the position.
- R8: A write to the position takes effect only when the value is no greater than the ceiling. A larger value leaves the position unchanged. A write of exactly the ceiling is accepted.
- R9: An up step with the position at or above the ceiling gives 0. A down step at 0 gives the ceiling.
- R10: A control write that clears the enable bit while it is set loads the reload value into the position.
- R11: An input level held for fewer than FILT_LEN consecutive synchronised samples is discarded and produces no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder input A, asynchronous to the clock |
| enc_b | input | 1 | Encoder input B, asynchronous to the clock |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| position | output | CNT_W | Current position count |

## Verification
Quadrature is driven forward and then backward through the wrap at zero, which tests the direction sense. A simultaneous change of both inputs tests that the illegal jump is rejected, and short pulses on A test that the glitch filter discards them. Pulse trains in pulse/direction mode are sent first with B high and then with B low, which shows that B steers the direction while falling edges of A are not counted. In the up-only and down-only modes, pulse trains with B toggling between pulses show that B has no effect. Running these trains with the both-edges bit set and then cleared shows that the bit halves or doubles the count, and the up-only trains run past the ceiling to test the wrap. Register writes then check:

- the reload that happens when the enable bit is cleared;
- that steps are frozen while counting is disabled;
- the position write at the ceiling, below it and above it.

// File: rtl/enc_pos_pkg.sv
package enc_pos_pkg;

   typedef enum logic [1:0] {
      MODE_QUAD = 2'd0,
      MODE_PDIR = 2'd1,
      MODE_UP   = 2'd2,
      MODE_DOWN = 2'd3
   } cnt_mode_e;

   typedef struct packed {
      logic up;
      logic dn;
   } step_t;

   // byte offsets of the register window
   localparam int OFS_COUNT  = 'h00;
   localparam int OFS_INIT   = 'h04;
   localparam int OFS_MAX    = 'h08;
   localparam int OFS_DECCTL = 'h28;
   localparam int OFS_CTL    = 'h2A;

   // field positions inside the 16-bit control words
   localparam int MODE_LSB = 14;
   localparam int DBL_BIT  = 11;
   localparam int EN_BIT   = 3;

endpackage

// File: rtl/enc_sync_filter.sv
module enc_sync_filter #(
   parameter int WIDTH       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] clean_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "enc_sync_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $fatal(1, "enc_sync_filter: FILT_LEN must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   sync_s;
      logic                   clean_b;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[i]};
      end
      assign sync_s = sync_q[SYNC_STAGES-1];

      if (FILT_LEN == 1) begin : g_pass
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= sync_s;
         end
         assign clean_b = hold_q;
      end else begin : g_filt
         localparam int RUN_W = $clog2(FILT_LEN);
         logic [RUN_W-1:0] run_q;
         logic             level_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q   <= '0;
               level_q <= 1'b0;
            end else if (sync_s != level_q) begin
               if (run_q == RUN_W'(FILT_LEN - 1)) begin
                  level_q <= sync_s;
                  run_q   <= '0;
               end else begin
                  run_q <= run_q + RUN_W'(1);
               end
            end else begin
               run_q <= '0;
            end
         end
         assign clean_b = level_q;
      end

      assign clean_o[i] = clean_b;
   end

endmodule

// File: rtl/enc_step_decode.sv
module enc_step_decode
   import enc_pos_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  cnt_mode_e mode_i,
   input  logic      dbl_edge_i,
   input  logic      a_i,
   input  logic      b_i,
   output step_t     step_o,
   output logic      a_chg_o,
   output logic      b_chg_o
);

   logic a_q, b_q;
   logic a_rise, a_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= a_i;
         b_q <= b_i;
      end
   end

   assign a_chg_o = a_i ^ a_q;
   assign b_chg_o = b_i ^ b_q;
   assign a_rise  = a_i & ~a_q;
   assign a_tick  = dbl_edge_i ? a_chg_o : a_rise;

   always_comb begin
      step_o = '0;
      unique case (mode_i)
         MODE_QUAD: begin
            // exactly one input moved: A ahead of B means forward
            if (a_chg_o ^ b_chg_o) begin
               if (a_i ^ b_q) step_o.up = 1'b1;
               else           step_o.dn = 1'b1;
            end
         end
         MODE_PDIR: begin
            if (a_rise) begin
               if (b_i) step_o.up = 1'b1;
               else     step_o.dn = 1'b1;
            end
         end
         MODE_UP:   step_o.up = a_tick;
         MODE_DOWN: step_o.dn = a_tick;
         default:   step_o = '0;
      endcase
   end

endmodule

// File: rtl/enc_pos_core.sv
module enc_pos_core
   import enc_pos_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  step_t            step_i,
   input  logic             load_init_i,
   input  logic [CNT_W-1:0] init_i,
   input  logic             wr_ok_i,
   input  logic [CNT_W-1:0] wr_val_i,
   input  logic [CNT_W-1:0] max_i,
   output logic [CNT_W-1:0] pos_o
);

   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] pos_inc, pos_dec;

   assign pos_inc = (pos_q >= max_i) ? '0 : pos_q + CNT_W'(1);
   assign pos_dec = (pos_q == '0) ? max_i : pos_q - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pos_q <= '0;
      else if (wr_ok_i)             pos_q <= wr_val_i;
      else if (load_init_i)         pos_q <= init_i;
      else if (en_i && step_i.up)   pos_q <= pos_inc;
      else if (en_i && step_i.dn)   pos_q <= pos_dec;
   end

   assign pos_o = pos_q;

endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
   import enc_pos_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CNT_W-1:0]  position
);

   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_INIT   = ADDR_W'(OFS_INIT);
   localparam logic [ADDR_W-1:0] A_MAX    = ADDR_W'(OFS_MAX);
   localparam logic [ADDR_W-1:0] A_DECCTL = ADDR_W'(OFS_DECCTL);
   localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFS_CTL);

   if (DATA_W < CNT_W) begin : g_bad_data
      $fatal(1, "enc_pos_counter: DATA_W must cover CNT_W");
   end
   if (DATA_W < 16) begin : g_bad_ctl
      $fatal(1, "enc_pos_counter: DATA_W must hold a 16-bit control word");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $fatal(1, "enc_pos_counter: ADDR_W too small for the register window");
   end

   // register state
   logic [CNT_W-1:0] init_q, max_q;
   cnt_mode_e        mode_q;
   logic             dbl_q, en_q;

   logic wr_count, wr_init, wr_max, wr_dec, wr_ctl;
   logic wfits, wr_ok, en_clear;

   assign wr_count = bus_wr && (bus_addr == A_COUNT);
   assign wr_init  = bus_wr && (bus_addr == A_INIT);
   assign wr_max   = bus_wr && (bus_addr == A_MAX);
   assign wr_dec   = bus_wr && (bus_addr == A_DECCTL);
   assign wr_ctl   = bus_wr && (bus_addr == A_CTL);

   if (DATA_W > CNT_W) begin : g_wide
      assign wfits = ~|bus_wdata[DATA_W-1:CNT_W];
   end else begin : g_exact
      assign wfits = 1'b1;
   end

   assign wr_ok    = wr_count && wfits && (bus_wdata[CNT_W-1:0] <= max_q);
   assign en_clear = wr_ctl && en_q && !bus_wdata[EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= '0;
         max_q  <= '1;
         mode_q <= MODE_QUAD;
         dbl_q  <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (wr_init) init_q <= bus_wdata[CNT_W-1:0];
         if (wr_max)  max_q  <= bus_wdata[CNT_W-1:0];
         if (wr_dec) begin
            mode_q <= cnt_mode_e'(bus_wdata[MODE_LSB+1:MODE_LSB]);
            dbl_q  <= bus_wdata[DBL_BIT];
         end
         if (wr_ctl)  en_q <= bus_wdata[EN_BIT];
      end
   end

   // read path
   logic [15:0] dec_word, ctl_word;
   always_comb begin
      dec_word = '0;
      dec_word[MODE_LSB+1:MODE_LSB] = mode_q;
      dec_word[DBL_BIT] = dbl_q;
      ctl_word = '0;
      ctl_word[EN_BIT] = en_q;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_COUNT:  bus_rdata[CNT_W-1:0] = position;
         A_INIT:   bus_rdata[CNT_W-1:0] = init_q;
         A_MAX:    bus_rdata[CNT_W-1:0] = max_q;
         A_DECCTL: bus_rdata[15:0]      = dec_word;
         A_CTL:    bus_rdata[15:0]      = ctl_word;
         default:  bus_rdata = '0;
      endcase
   end

   // datapath
   logic [1:0] clean_ab;
   step_t      step;
   logic       a_chg, b_chg;

   enc_sync_filter #(
      .WIDTH      (2),
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
   ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  ({enc_a, enc_b}),
      .clean_o(clean_ab)
   );

   enc_step_decode u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_q),
      .dbl_edge_i(dbl_q),
      .a_i       (clean_ab[1]),
      .b_i       (clean_ab[0]),
      .step_o    (step),
      .a_chg_o   (a_chg),
      .b_chg_o   (b_chg)
   );

   enc_pos_core #(
      .CNT_W(CNT_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_q),
      .step_i     (step),
      .load_init_i(en_clear),
      .init_i     (init_q),
      .wr_ok_i    (wr_ok),
      .wr_val_i   (bus_wdata[CNT_W-1:0]),
      .max_i      (max_q),
      .pos_o      (position)
   );

endmodule

// File: rtl/enc_pos_counter_chk.sv
module enc_pos_counter_chk
   import enc_pos_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [CNT_W-1:0]  position,
   input logic [CNT_W-1:0]  max_q,
   input logic [CNT_W-1:0]  init_q,
   input logic              en_q,
   input cnt_mode_e         mode_q,
   input step_t             step,
   input logic              a_chg,
   input logic              b_chg
);

   logic hit_count, hit_ctl;
   assign hit_count = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
   assign hit_ctl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));

   // R8
   count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_count && bus_wdata <= DATA_W'(max_q)) |=> position == $past(bus_wdata[CNT_W-1:0]));

   // R10
   init_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ctl && en_q && !bus_wdata[EN_BIT]) |=> position == $past(init_q));

   // R7
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !hit_count) |=> $stable(position));

   // R9
   wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && step.up && position >= max_q && !hit_count && !hit_ctl) |=> position == '0);

   // R9
   wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && step.dn && position == '0 && !hit_count && !hit_ctl) |=> position == $past(max_q));

   // R4
   illegal_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_QUAD && a_chg && b_chg) |-> !(step.up || step.dn));

   // R3
   one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({step.up, step.dn}));

endmodule

bind enc_pos_counter enc_pos_counter_chk #(
   .CNT_W (CNT_W),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .position (position),
   .max_q    (max_q),
   .init_q   (init_q),
   .en_q     (en_q),
   .mode_q   (mode_q),
   .step     (step),
   .a_chg    (a_chg),
   .b_chg    (b_chg)
);

// File: tb/enc_pos_counter_test.sv
module enc_pos_counter_test;

   localparam int CNT_W  = 32;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 6;
   localparam int FILT   = 3;
   localparam int HOLD   = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enc_a = 1'b0;
   logic              enc_b = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic [CNT_W-1:0]  position;

   always #2 clk = ~clk;

   enc_pos_counter #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .SYNC_STAGES(2), .FILT_LEN(FILT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .position(position)
   );

   int    vectors = 0;
   int    fails   = 0;
   bit    started = 0;
   string cur_req = "R1";

   // ---------------- reference model ----------------
   logic [31:0] m_pos, m_init, m_max;
   logic [1:0]  m_mode;
   bit          m_dbl, m_en;
   bit          ha[8], hb[8];
   bit          fa, fb, fa_q, fb_q;

   function automatic int gray_idx(bit a, bit b);
      if (!a && !b) return 0;
      if ( a && !b) return 1;
      if ( a &&  b) return 2;
      return 3;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_init = 0; m_max = 32'hFFFF_FFFF;
         m_mode = 0; m_dbl = 0; m_en = 0;
         foreach (ha[k]) begin ha[k] = 0; hb[k] = 0; end
         fa = 0; fb = 0; fa_q = 0; fb_q = 0;
      end else begin
         bit up, dn, agree_a, agree_b;
         up = 0; dn = 0;
         case (m_mode)
            2'd0: if ((fa != fa_q) != (fb != fb_q)) begin
                     int d;
                     d = (gray_idx(fa, fb) - gray_idx(fa_q, fb_q) + 4) % 4;
                     up = (d == 1);
                     dn = (d == 3);
                  end
            2'd1: if (fa && !fa_q) begin up = fb; dn = !fb; end
            2'd2: up = m_dbl ? (fa != fa_q) : (fa && !fa_q);
            default: dn = m_dbl ? (fa != fa_q) : (fa && !fa_q);
         endcase
         if (bus_wr && bus_addr == 6'h00) begin
            if (bus_wdata <= m_max) m_pos = bus_wdata;
         end else if (bus_wr && bus_addr == 6'h2A && m_en && !bus_wdata[3]) begin
            m_pos = m_init;
         end else if (m_en && up) begin
            m_pos = (m_pos >= m_max) ? 32'd0 : m_pos + 1;
         end else if (m_en && dn) begin
            m_pos = (m_pos == 0) ? m_max : m_pos - 1;
         end
         if (bus_wr) begin
            case (bus_addr)
               6'h04: m_init = bus_wdata;
               6'h08: m_max  = bus_wdata;
               6'h28: begin m_mode = bus_wdata[15:14]; m_dbl = bus_wdata[11]; end
               6'h2A: m_en = bus_wdata[3];
               default: ;
            endcase
         end
         for (int k = 7; k > 0; k--) begin ha[k] = ha[k-1]; hb[k] = hb[k-1]; end
         ha[0] = enc_a; hb[0] = enc_b;
         agree_a = 1; agree_b = 1;
         for (int k = 3; k <= FILT + 1; k++) begin
            if (ha[k] != ha[2]) agree_a = 0;
            if (hb[k] != hb[2]) agree_b = 0;
         end
         fa_q = fa; fb_q = fb;
         if (agree_a) fa = ha[2];
         if (agree_b) fb = hb[2];
      end
   end

   function automatic logic [31:0] model_read(logic [5:0] a);
      case (a)
         6'h00: return m_pos;
         6'h04: return m_init;
         6'h08: return m_max;
         6'h28: return {16'h0, m_mode, 2'b00, m_dbl, 11'h0};
         6'h2A: return {28'h0, m_en, 3'b000};
         default: return 32'h0;
      endcase
   endfunction

   // every-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         vectors++;
         if (position !== m_pos) begin
            fails++;
            $display("FAIL %s: position got %0d expected %0d", cur_req, position, m_pos);
         end
         if (bus_rdata !== model_read(bus_addr)) begin
            fails++;
            $display("FAIL %s: rdata@%0h got %0h expected %0h", cur_req, bus_addr,
                     bus_rdata, model_read(bus_addr));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      tick(1);
      bus_wr = 0; bus_addr = 6'h00;
   endtask

   task automatic set_ab(bit a, bit b);
      enc_a = a; enc_b = b;
      tick(HOLD);
   endtask

   int g = 0;
   task automatic quad_step(bit fwd);
      g = fwd ? (g + 1) % 4 : (g + 3) % 4;
      case (g)
         0: set_ab(0, 0);
         1: set_ab(1, 0);
         2: set_ab(1, 1);
         default: set_ab(0, 1);
      endcase
   endtask

   task automatic check_pos(string req, logic [31:0] exp);
      #1;
      vectors++;
      if (position !== exp) begin
         fails++;
         $display("FAIL %s: position got %0d expected %0d", req, position, exp);
      end
   endtask

   task automatic check_rd(string req, logic [5:0] a, logic [31:0] exp);
      bus_addr = a;
      #1;
      vectors++;
      if (bus_rdata !== exp) begin
         fails++;
         $display("FAIL %s: rdata@%0h got %0h expected %0h", req, a, bus_rdata, exp);
      end
      bus_addr = 6'h00;
   endtask

   task automatic run_all();
      tick(4);
      rst_n = 1;
      started = 1;
      tick(2);
      // R1 reset values
      cur_req = "R1";
      check_pos("R1", 0);
      check_rd("R1", 6'h08, 32'hFFFF_FFFF);
      check_rd("R1", 6'h2A, 32'h0);
      // R2 set up ceiling 20, reload 5, quadrature, enabled
      cur_req = "R2";
      wr(6'h08, 20); wr(6'h04, 5); wr(6'h28, 32'h0000); wr(6'h2A, 32'h0008);
      wr(6'h00, 5);
      check_rd("R2", 6'h04, 5);
      check_rd("R2", 6'h2A, 32'h0008);
      // R3 forward 12, then backward through zero (R9)
      cur_req = "R3";
      for (int i = 0; i < 12; i++) quad_step(1);
      tick(10);
      check_pos("R3", 17);
      cur_req = "R9";
      for (int i = 0; i < 30; i++) quad_step(0);
      tick(10);
      check_pos("R9", 8);
      // R4 both inputs change together
      cur_req = "R4";
      g = (g + 2) % 4;
      case (g)
         0: set_ab(0, 0);
         1: set_ab(1, 0);
         2: set_ab(1, 1);
         default: set_ab(0, 1);
      endcase
      tick(10);
      check_pos("R4", 8);
      // R11 short pulses on A
      cur_req = "R11";
      enc_a = ~enc_a; tick(1); enc_a = ~enc_a; tick(4);
      enc_a = ~enc_a; tick(2); enc_a = ~enc_a; tick(10);
      check_pos("R11", 8);
      // R5 pulse/direction
      cur_req = "R5";
      wr(6'h28, 32'h4000);
      for (int i = 0; i < 3; i++) begin set_ab(0, 1); set_ab(1, 1); end
      for (int i = 0; i < 5; i++) begin set_ab(0, 0); set_ab(1, 0); end
      tick(10);
      check_pos("R5", 6);
      // R6 up-only, single then both edges, B toggling
      cur_req = "R6";
      wr(6'h28, 32'h8000);
      for (int i = 0; i < 4; i++) begin set_ab(0, i[0]); set_ab(1, !i[0]); end
      tick(10);
      check_pos("R6", 10);
      wr(6'h28, 32'h8800);
      for (int i = 0; i < 6; i++) begin set_ab(0, i[0]); set_ab(1, !i[0]); end
      tick(10);
      check_pos("R9", 1);
      // R6 down-only through zero
      wr(6'h28, 32'hC000);
      for (int i = 0; i < 3; i++) begin set_ab(0, i[0]); set_ab(1, i[0]); end
      tick(10);
      check_pos("R6", 19);
      check_rd("R2", 6'h28, 32'hC000);
      check_rd("R2", 6'h10, 32'h0);
      // R10 clearing enable reloads, R7 steps frozen
      cur_req = "R10";
      wr(6'h2A, 32'h0000);
      check_pos("R10", 5);
      cur_req = "R7";
      for (int i = 0; i < 3; i++) begin set_ab(0, 0); set_ab(1, 0); end
      tick(10);
      check_pos("R7", 5);
      // R8 position writes
      cur_req = "R8";
      wr(6'h00, 7);
      check_pos("R8", 7);
      wr(6'h00, 50);
      check_pos("R8", 7);
      wr(6'h00, 20);
      check_pos("R8", 20);
      // R2 reserved decoder bits read back as zero
      cur_req = "R2";
      wr(6'h28, 32'hFFFF);
      check_rd("R2", 6'h28, 32'hC800);
      tick(4);
   endtask

   bit timed_out = 0;
   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      if (timed_out) begin
         fails++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule